// File: doc/BRIEF.md
# Bus Idle Gap Controller

This block sits inside an external bus controller and enforces the quiet time between two external accesses. When an access finishes, the controller records what kind of access it was (chip-select space, read or write, DMA single-address transfer, SDRAM target). At the same moment it takes a copy of the programmable idle settings that belong to that access. From then on it counts idle clocks. It compares the count against the gap that the pending request needs, and it raises `ready` only when that gap has elapsed.

Three rules can set the gap. A completed DMA single-address transfer uses one dedicated 3-bit setting. Any other completed access uses one of eight 3-bit settings owned by the space it touched. The setting is chosen by whether the next access targets the same space, whether the previous access was a write, and whether the next one is a write. When the completed access went to SDRAM, a 2-bit setting of 0 to 3 cycles also applies, and the larger of the applicable gaps wins. The 3-bit settings map nonlinearly onto 0 to 12 cycles.

The control is a three-state machine. FREE means no gap is pending. ACCESS means an external access is in flight. GAP means idle cycles are being counted. The transitions are: FREE to ACCESS on a grant, ACCESS to GAP on access completion, GAP to ACCESS on a grant, and GAP to FREE once the idle count reaches the 12-cycle ceiling.

Top module: `idle_gap_ctrl`

## Requirements
- R1: A 3-bit idle code c gives a gap as follows: 3'b000→0, 3'b001→1, 3'b010→2, 3'b011→4, 3'b100→6, 3'b101→8, 3'b110→10, 3'b111→12 cycles.
- R2: When the completed access was a DMA single-address transfer (`done_dma_sa`=1), the gap comes from `cfg_dma_idle` and the per-space codes are ignored. A code of 0 grants a waiting request in the very next cycle, with no idle cycle between transfers.
- R3: For any other completed access to space s, the gap comes from `cfg_space_idle[(s*8+k)*3 +: 3]`. Here k = 4*same + 2*prev_wr + next_wr, where same=1 when `req_cs` equals the completed space.
- R4: When the completed access was to SDRAM (`done_sdram`=1), a gap of `cfg_sdram_idle` cycles (0 to 3) also applies. The gap used is the maximum of this value and the gap from R2 or R3.
- R5: Let `acc_done` be sampled in cycle T while a request is held. Then `grant` is high in cycle T+1+gap and not earlier. With a gap of 0, `ready` is high in cycle T+1.
- R6: `ready` and `grant` stay low while an access is in flight, even if `req_valid` is high.
- R7: The idle settings are captured when the access completes. Changing any `cfg_*` input during a gap does not alter that gap.
- R8: After reset the block is in FREE, with `ready`=1, `bus_idle`=1, and `grant`=0 while no request is made.
- R9: `bus_idle` is 0 from the cycle after a grant through the cycle in which `acc_done` is sampled, and 1 at all other times.
- R10: Once 12 idle cycles have passed since completion, any request is granted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A next access is pending |
| req_cs | input | CS_W | Chip-select space of the pending access |
| req_wr | input | 1 | Pending access is a write |
| acc_done | input | 1 | One-cycle pulse: the current access has completed |
| done_cs | input | CS_W | Space of the completed access |
| done_wr | input | 1 | Completed access was a write |
| done_dma_sa | input | 1 | Completed access was a DMA single-address transfer |
| done_sdram | input | 1 | Completed access targeted SDRAM |
| cfg_dma_idle | input | 3 | Idle code for DMA single-address transfers |
| cfg_space_idle | input | NUM_CS*24 | Eight 3-bit idle codes per space |
| cfg_sdram_idle | input | 2 | SDRAM idle cycles, 0 to 3 |
| ready | output | 1 | The pending access may start in this cycle |
| grant | output | 1 | ready and req_valid: the access starts now |
| bus_idle | output | 1 | No access is in flight |

## Verification
The assertions assume that `acc_done` pulses only while an access is in flight, meaning after a grant and before the next completion. They also assume that the completion descriptor is valid in the pulse cycle. The bench follows this order in every scenario: it requests and receives a grant, drops the request, pulses `acc_done` for exactly one cycle, and then presents the next request. It waits out the full ceiling before each new measurement, so every gap is measured from a known FREE start.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } gap_state_e;

    localparam int CODE_W      = 3;
    localparam int SD_W        = 2;
    localparam int CNT_W       = 4;
    localparam int GAP_MAX     = 12;
    localparam int COMBOS      = 8;
    localparam int SPACE_BITS  = COMBOS * CODE_W;

    typedef struct packed {
        logic wr;
        logic dma_sa;
        logic sdram;
    } acc_kind_t;

    function automatic logic [CNT_W-1:0] code_to_cycles(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] wide;
        wide = {{(CNT_W-CODE_W){1'b0}}, code};
        if (code < 3'd3) begin
            return wide;
        end
        return (wide - 4'd1) << 1;
    endfunction

endpackage

// File: rtl/idle_gap_select.sv
module idle_gap_select
    import idle_gap_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [CS_W-1:0]       prev_cs,
    input  acc_kind_t             prev_kind,
    input  logic [SPACE_BITS-1:0] prev_space_codes,
    input  logic [CODE_W-1:0]     prev_dma_code,
    input  logic [SD_W-1:0]       prev_sdram_code,
    input  logic [CS_W-1:0]       next_cs,
    input  logic                  next_wr,
    output logic [CNT_W-1:0]      gap
);

    logic                  same_space;
    logic [2:0]            combo;
    logic [CODE_W-1:0]     space_code;
    logic [CNT_W-1:0]      primary_gap;
    logic [CNT_W-1:0]      sdram_gap;

    always_comb begin
        same_space  = (next_cs == prev_cs);
        combo       = {same_space, prev_kind.wr, next_wr};
        space_code  = prev_space_codes[int'(combo)*CODE_W +: CODE_W];

        if (prev_kind.dma_sa) begin
            primary_gap = code_to_cycles(prev_dma_code);
        end else begin
            primary_gap = code_to_cycles(space_code);
        end

        if (prev_kind.sdram) begin
            sdram_gap = {{(CNT_W-SD_W){1'b0}}, prev_sdram_code};
        end else begin
            sdram_gap = '0;
        end

        gap = (sdram_gap > primary_gap) ? sdram_gap : primary_gap;
    end

endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
    import idle_gap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] CEIL = CNT_W'(GAP_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= CEIL;
        end else if (clear) begin
            elapsed <= '0;
        end else if (run && (elapsed != CEIL)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // R5: counting is one idle cycle per clock from the completion point
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && elapsed < CEIL) |=> (elapsed == $past(elapsed) + 1'b1));

    a_r5_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (elapsed == '0));

    a_r10_count_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed <= CEIL);

endmodule

// File: rtl/idle_gap_ctrl.sv
module idle_gap_ctrl
    import idle_gap_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [CS_W-1:0]          req_cs,
    input  logic                     req_wr,
    input  logic                     acc_done,
    input  logic [CS_W-1:0]          done_cs,
    input  logic                     done_wr,
    input  logic                     done_dma_sa,
    input  logic                     done_sdram,
    input  logic [CODE_W-1:0]        cfg_dma_idle,
    input  logic [NUM_CS*SPACE_BITS-1:0] cfg_space_idle,
    input  logic [SD_W-1:0]          cfg_sdram_idle,
    output logic                     ready,
    output logic                     grant,
    output logic                     bus_idle
);

    localparam logic [CNT_W-1:0] CEIL = CNT_W'(GAP_MAX);

    gap_state_e              state_q;
    gap_state_e              state_d;

    logic [CS_W-1:0]         snap_cs_q;
    acc_kind_t               snap_kind_q;
    logic [SPACE_BITS-1:0]   snap_space_q;
    logic [CODE_W-1:0]       snap_dma_q;
    logic [SD_W-1:0]         snap_sdram_q;

    logic                    capture;
    logic [CNT_W-1:0]        elapsed;
    logic [CNT_W-1:0]        gap_need;

    assign capture = (state_q == ST_ACCESS) && acc_done;

    // Snapshot of the completed access and of its idle settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_cs_q    <= '0;
            snap_kind_q  <= '0;
            snap_space_q <= '0;
            snap_dma_q   <= '0;
            snap_sdram_q <= '0;
        end else if (capture) begin
            snap_cs_q    <= done_cs;
            snap_kind_q  <= '{wr: done_wr, dma_sa: done_dma_sa, sdram: done_sdram};
            snap_space_q <= cfg_space_idle[int'(done_cs)*SPACE_BITS +: SPACE_BITS];
            snap_dma_q   <= cfg_dma_idle;
            snap_sdram_q <= cfg_sdram_idle;
        end
    end

    idle_gap_select #(.NUM_CS(NUM_CS)) u_select (
        .prev_cs          (snap_cs_q),
        .prev_kind        (snap_kind_q),
        .prev_space_codes (snap_space_q),
        .prev_dma_code    (snap_dma_q),
        .prev_sdram_code  (snap_sdram_q),
        .next_cs          (req_cs),
        .next_wr          (req_wr),
        .gap              (gap_need)
    );

    idle_gap_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (capture),
        .run     (state_q == ST_GAP),
        .elapsed (elapsed)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (grant) state_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (acc_done) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (grant) begin
                    state_d = ST_ACCESS;
                end else if (elapsed == CEIL) begin
                    state_d = ST_FREE;
                end
            end
            default: state_d = ST_FREE;
        endcase
    end

    // Outputs
    always_comb begin
        ready    = 1'b0;
        bus_idle = 1'b1;
        unique case (state_q)
            ST_FREE:   ready = 1'b1;
            ST_ACCESS: bus_idle = 1'b0;
            ST_GAP:    ready = (elapsed >= gap_need);
            default: begin
                ready    = 1'b0;
                bus_idle = 1'b1;
            end
        endcase
        grant = ready && req_valid;
    end

    a_r6_no_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS) |-> !ready);

    a_r9_grant_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !bus_idle);

    a_r5_done_opens_gap: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state_q == ST_GAP && elapsed == '0));

    a_r7_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> ($stable(snap_space_q) && $stable(snap_dma_q) && $stable(snap_sdram_q)));

    a_r10_free_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE) |-> ready);

    a_r1_gap_range: assert property (@(posedge clk) disable iff (!rst_n)
        gap_need <= CEIL);

endmodule

// File: tb/idle_gap_ctrl_tb.sv
module idle_gap_ctrl_tb;

    localparam int NUM_CS = 4;
    localparam int CS_W   = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic [CS_W-1:0]       req_cs = '0;
    logic                  req_wr = 1'b0;
    logic                  acc_done = 1'b0;
    logic [CS_W-1:0]       done_cs = '0;
    logic                  done_wr = 1'b0;
    logic                  done_dma_sa = 1'b0;
    logic                  done_sdram = 1'b0;
    logic [2:0]            cfg_dma_idle = '0;
    logic [NUM_CS*24-1:0]  cfg_space_idle = '0;
    logic [1:0]            cfg_sdram_idle = '0;
    logic                  ready;
    logic                  grant;
    logic                  bus_idle;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    idle_gap_ctrl #(.NUM_CS(NUM_CS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_cs(req_cs), .req_wr(req_wr),
        .acc_done(acc_done), .done_cs(done_cs), .done_wr(done_wr),
        .done_dma_sa(done_dma_sa), .done_sdram(done_sdram),
        .cfg_dma_idle(cfg_dma_idle), .cfg_space_idle(cfg_space_idle),
        .cfg_sdram_idle(cfg_sdram_idle),
        .ready(ready), .grant(grant), .bus_idle(bus_idle)
    );

    function automatic int code_cycles(input logic [2:0] c);
        int tbl [8] = '{0, 1, 2, 4, 6, 8, 10, 12};
        return tbl[c];
    endfunction

    function automatic int expect_gap(input int pcs, input bit pwr, input bit pdma,
                                      input bit psd, input int ncs, input bit nwr);
        int k;
        int g;
        k = ((pcs == ncs) ? 4 : 0) + (pwr ? 2 : 0) + (nwr ? 1 : 0);
        if (pdma) g = code_cycles(cfg_dma_idle);
        else      g = code_cycles(cfg_space_idle[(pcs*8+k)*3 +: 3]);
        if (psd && int'(cfg_sdram_idle) > g) g = int'(cfg_sdram_idle);
        return g;
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic set_code(input int s, input int k, input logic [2:0] c);
        cfg_space_idle[(s*8+k)*3 +: 3] = c;
    endtask

    // One full measurement: access 'prev', completion, then request 'next'
    task automatic measure(input string req, input int pcs, input bit pwr, input bit pdma,
                           input bit psd, input int ncs, input bit nwr, input bit scramble);
        int exp_gap;
        int n;
        logic [2:0]           sv_dma;
        logic [NUM_CS*24-1:0] sv_space;
        logic [1:0]           sv_sd;
        @(negedge clk);
        req_valid = 1'b0;
        acc_done  = 1'b0;
        repeat (14) @(negedge clk);
        #1;
        check("R10 ready after ceiling", int'(ready), 1);
        req_valid = 1'b1; req_cs = CS_W'(pcs); req_wr = pwr;
        @(negedge clk);
        #1;
        check("R6 no ready during access", int'(ready), 0);
        check("R9 bus busy during access", int'(bus_idle), 0);
        exp_gap = expect_gap(pcs, pwr, pdma, psd, ncs, nwr);
        req_valid = 1'b0;
        acc_done = 1'b1; done_cs = CS_W'(pcs); done_wr = pwr;
        done_dma_sa = pdma; done_sdram = psd;
        @(negedge clk);
        acc_done = 1'b0; done_dma_sa = 1'b0; done_sdram = 1'b0;
        req_valid = 1'b1; req_cs = CS_W'(ncs); req_wr = nwr;
        sv_dma = cfg_dma_idle; sv_space = cfg_space_idle; sv_sd = cfg_sdram_idle;
        if (scramble) begin
            cfg_dma_idle = 3'b111; cfg_space_idle = '1; cfg_sdram_idle = 2'd3;
        end
        #1;
        n = 0;
        while (!ready && n < 20) begin
            n++;
            @(negedge clk);
            #1;
        end
        check(req, n, exp_gap);
        check("R5 grant with ready", int'(grant), 1);
        check("R9 bus idle during gap", int'(bus_idle), 1);
        @(negedge clk);
        cfg_dma_idle = sv_dma; cfg_space_idle = sv_space; cfg_sdram_idle = sv_sd;
        req_valid = 1'b0;
        acc_done = 1'b1; done_cs = '0; done_wr = 1'b0;
        @(negedge clk);
        acc_done = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R8 reset ready", int'(ready), 1);
        check("R8 reset bus_idle", int'(bus_idle), 1);
        check("R8 reset grant", int'(grant), 0);
    endtask

    task automatic t_code_map();
        cfg_space_idle = '0;
        for (int c = 0; c < 8; c++) begin
            set_code(0, 0, 3'(c));
            measure("R1 code map", 0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
        end
    endtask

    task automatic t_space_combos();
        for (int k = 0; k < 8; k++) set_code(2, k, 3'(k));
        for (int k = 0; k < 8; k++) begin
            measure("R3 combo select", 2, k[1], 1'b0, 1'b0, k[2] ? 2 : 3, k[0], 1'b0);
        end
        measure("R3 other space codes ignored", 1, 1'b1, 1'b0, 1'b0, 2, 1'b1, 1'b0);
    endtask

    task automatic t_dma();
        cfg_space_idle = '1;
        cfg_dma_idle = 3'b010;
        measure("R2 dma code used", 1, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b0);
        cfg_dma_idle = 3'b000;
        measure("R2 dma zero no gap", 3, 1'b1, 1'b1, 1'b0, 3, 1'b1, 1'b0);
    endtask

    task automatic t_sdram();
        cfg_space_idle = '0;
        cfg_sdram_idle = 2'd3;
        measure("R4 sdram over zero", 0, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0);
        set_code(0, 4, 3'b011);
        cfg_sdram_idle = 2'd2;
        measure("R4 space over sdram", 0, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0);
        cfg_dma_idle = 3'b000;
        cfg_sdram_idle = 2'd1;
        measure("R4 sdram over dma zero", 1, 1'b0, 1'b1, 1'b1, 2, 1'b1, 1'b0);
    endtask

    task automatic t_sampling();
        cfg_space_idle = '0;
        cfg_sdram_idle = 2'd0;
        cfg_dma_idle   = 3'b000;
        set_code(1, 1, 3'b001);
        measure("R7 mid-gap change ignored", 1, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1);
        cfg_dma_idle = 3'b000;
        measure("R7 dma zero kept", 2, 1'b0, 1'b1, 1'b0, 2, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_code_map();
        t_space_combos();
        t_dma();
        t_sdram();
        t_sampling();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule